// File: doc/BRIEF.md
# Multi-Source Interrupt Aggregator

This block gathers interrupt requests from four serial channels and reports them on a single active-high local interrupt line. Each channel has five request sources: four FIFO-status flags (transmit empty, transmit full, receive empty, receive full) and one serial-controller interrupt. The request inputs are asynchronous, so each one passes through a two-flop synchronizer before it is evaluated.

Each source has three configuration bits: an enable, a mode bit that selects edge or level sensing, and a sense bit that selects rising/high or falling/low. In edge mode, a qualifying transition sets a sticky status bit. Software clears that bit by writing a 1 to it. In level mode, the status bit shows the live, sense-corrected input, and writing to clear it has no effect.

The interrupt line is the OR over all sources of status AND enable, taken through one register. The host reaches the four configuration and status registers through a simple 32-bit register port. Reads are combinational and writes take effect on the clock edge.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all four registers read 0 and `irq_out` is 0. Every source therefore starts edge-sensitive, rising, disabled and clear.
- R2: The registers sit at byte offsets 0x60 (enable), 0x64 (status, write-one-to-clear), 0x68 (mode, 1 = level) and 0x6C (sense, 1 = falling/low). Each register uses bits 19:0 and reads 0 in bits 31:20. Any other address reads 0, and a write to it changes no register.
- R3: Source bit `ch*5+k` maps to channel `ch` (0 to 3). For k = 0..3 it is FIFO flag `fifo_flags[ch*4+k]` (0 transmit empty, 1 transmit full, 2 receive empty, 3 receive full). For k = 4 it is `ser_irq[ch]`.
- R4: In edge mode with sense 0, a rising input sets its status bit. The bit reads 1 three clock edges after the input changes. A falling input sets nothing.
- R5: In edge mode with sense 1, a falling input sets the status bit and a rising input does not.
- R6: An edge sets the status bit whether or not the source is enabled. The bit then holds until it is cleared.
- R7: Writing the status register clears every edge-mode bit written as 1 and leaves every bit written as 0 unchanged.
- R8: If an edge sets a bit on the same clock edge as a clear write to that bit, the bit ends up set.
- R9: In level mode, the status bit reads (synchronized input XOR sense) whatever the enable. A status write does not change it.
- R10: `irq_out` equals the OR over all sources of (status AND enable), delayed by exactly one clock. A disabled source never raises it.
- R11: After an edge interrupt, `irq_out` stays high until software clears the status bit. It falls one clock after the clearing write.
- R12: An input change reaches the status view after two synchronizer stages. A level bit shows it two edges later, and the status bit still reads 0 two edges after a qualifying edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_flags | input | 16 | Raw FIFO flags, four per channel |
| ser_irq | input | 4 | Raw serial-controller interrupt, one per channel |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Aggregated active-high interrupt |

## Verification
The assertions assume that the raw request inputs are low while reset is asserted, so that the first synchronized samples cannot look like an edge. They also assume that each write strobe lasts exactly one cycle. The bench holds every request input at zero through reset and pulses `reg_wr` for a single cycle in every write. Random request toggles are kept sparse enough that rising and falling edges on the same bit stay separate. Register traffic goes only to the four mapped offsets and to one unmapped offset.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Sources per channel: four FIFO flags plus one serial-controller request.
    localparam int FIFO_FLAGS_PER_CH = 4;
    localparam int SRC_PER_CH        = FIFO_FLAGS_PER_CH + 1;
    localparam int SER_SLOT          = FIFO_FLAGS_PER_CH;

    // Register byte offsets.
    localparam int OFS_ENABLE = 'h60;
    localparam int OFS_STATUS = 'h64;
    localparam int OFS_MODE   = 'h68;
    localparam int OFS_SENSE  = 'h6C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_STATUS,
        SEL_MODE,
        SEL_SENSE
    } reg_sel_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = raw_in;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stage2;
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_in,
    input  logic [W-1:0] mode_q,
    input  logic [W-1:0] sense_q,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] hit,
    output logic [W-1:0] sticky_q,
    output logic [W-1:0] status_view
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] sticky;
    } det_t;

    det_t st_d, st_q;
    logic [W-1:0] hit_d;

    // One lane per source: edge qualification and status view.
    for (genvar i = 0; i < W; i++) begin : g_lane
        logic rise, fall;
        assign rise     = sync_in[i] & ~st_q.prev[i];
        assign fall     = ~sync_in[i] & st_q.prev[i];
        assign hit_d[i] = ~mode_q[i] & (sense_q[i] ? fall : rise);
        assign status_view[i] = mode_q[i] ? (sync_in[i] ^ sense_q[i])
                                          : st_q.sticky[i];
    end

    always_comb begin
        st_d        = st_q;
        st_d.prev   = sync_in;
        // A new edge wins over a clear; level lanes keep no sticky state.
        st_d.sticky = ~mode_q & ((st_q.sticky & ~clr_mask) | hit_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit      = hit_d;
    assign sticky_q = st_q.sticky;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_agg_pkg::*;
#(
    parameter int W  = 20,
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    input  logic [W-1:0]  status_view,
    output logic [W-1:0]  en_q,
    output logic [W-1:0]  mode_q,
    output logic [W-1:0]  sense_q,
    output logic [W-1:0]  clr_mask,
    output logic [DW-1:0] reg_rdata
);
    localparam int PAD = DW - W;

    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] mode;
        logic [W-1:0] sense;
    } cfg_t;

    cfg_t     cfg_d, cfg_q;
    reg_sel_e sel;
    logic [W-1:0] wfield;
    logic [W-1:0] rfield;

    function automatic logic at_ofs(input logic [AW-1:0] a, input int ofs);
        logic [AW-1:0] o;
        o = AW'(ofs);
        return (a[AW-1:2] == o[AW-1:2]) && (a[1:0] == 2'b00);
    endfunction

    always_comb begin
        if      (at_ofs(reg_addr, OFS_ENABLE)) sel = SEL_ENABLE;
        else if (at_ofs(reg_addr, OFS_STATUS)) sel = SEL_STATUS;
        else if (at_ofs(reg_addr, OFS_MODE))   sel = SEL_MODE;
        else if (at_ofs(reg_addr, OFS_SENSE))  sel = SEL_SENSE;
        else                                   sel = SEL_NONE;
    end

    assign wfield = reg_wdata[W-1:0];

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            case (sel)
                SEL_ENABLE: cfg_d.en    = wfield;
                SEL_MODE:   cfg_d.mode  = wfield;
                SEL_SENSE:  cfg_d.sense = wfield;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign clr_mask = (reg_wr && sel == SEL_STATUS) ? wfield : '0;

    always_comb begin
        case (sel)
            SEL_ENABLE: rfield = cfg_q.en;
            SEL_STATUS: rfield = status_view;
            SEL_MODE:   rfield = cfg_q.mode;
            SEL_SENSE:  rfield = cfg_q.sense;
            default:    rfield = '0;
        endcase
    end

    if (PAD > 0) begin : g_pad
        assign reg_rdata = {{PAD{1'b0}}, rfield};
    end else begin : g_nopad
        assign reg_rdata = rfield[DW-1:0];
    end

    assign en_q    = cfg_q.en;
    assign mode_q  = cfg_q.mode;
    assign sense_q = cfg_q.sense;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DW     = 32,
    parameter int AW     = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_CH*FIFO_FLAGS_PER_CH-1:0] fifo_flags,
    input  logic [NUM_CH-1:0]               ser_irq,
    input  logic [AW-1:0]                   reg_addr,
    input  logic                            reg_wr,
    input  logic [DW-1:0]                   reg_wdata,
    output logic [DW-1:0]                   reg_rdata,
    output logic                            irq_out
);
    localparam int NSRC = NUM_CH * SRC_PER_CH;

    logic [NSRC-1:0] raw_src;
    logic [NSRC-1:0] sync_src;
    logic [NSRC-1:0] en_q, mode_q, sense_q, clr_mask;
    logic [NSRC-1:0] hit, sticky_q, status_view;

    // Pack each channel's sources into one contiguous group.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        for (genvar k = 0; k < FIFO_FLAGS_PER_CH; k++) begin : g_flag
            assign raw_src[ch*SRC_PER_CH + k] = fifo_flags[ch*FIFO_FLAGS_PER_CH + k];
        end
        assign raw_src[ch*SRC_PER_CH + SER_SLOT] = ser_irq[ch];
    end

    irq_sync #(.W(NSRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (raw_src),
        .sync_out (sync_src)
    );

    irq_detect #(.W(NSRC)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_in     (sync_src),
        .mode_q      (mode_q),
        .sense_q     (sense_q),
        .clr_mask    (clr_mask),
        .hit         (hit),
        .sticky_q    (sticky_q),
        .status_view (status_view)
    );

    irq_regs #(.W(NSRC), .DW(DW), .AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .status_view (status_view),
        .en_q        (en_q),
        .mode_q      (mode_q),
        .sense_q     (sense_q),
        .clr_mask    (clr_mask),
        .reg_rdata   (reg_rdata)
    );

    logic irq_d, irq_q;

    always_comb begin
        irq_d = |(status_view & en_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int NSRC = 20,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [DW-1:0]   reg_rdata,
    input logic            irq_out,
    input logic [NSRC-1:0] en_q,
    input logic [NSRC-1:0] mode_q,
    input logic [NSRC-1:0] hit,
    input logic [NSRC-1:0] clr_mask,
    input logic [NSRC-1:0] sticky_q,
    input logic [NSRC-1:0] status_view
);
    // R10: output is the registered OR of enabled status
    a_r10_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(|(status_view & en_q)));

    // R10: a raised output needs some enable in the previous cycle
    a_r10_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(en_q != '0));

    // R7: bits written as 1 without a new edge are cleared
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((sticky_q & $past(clr_mask & ~hit)) == '0));

    // R8: an edge always lands in status, clear or not
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((sticky_q & $past(hit)) == $past(hit)));

    // R6: uncleared edge-mode status bits hold
    a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q & $past(sticky_q & ~clr_mask & ~mode_q))
            == $past(sticky_q & ~clr_mask & ~mode_q));

    // R9: level-mode lanes carry no sticky state
    a_r9_level_no_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q & $past(mode_q)) == '0);

    // R2: unused read bits are zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DW-1:NSRC] == '0);
endmodule

bind irq_aggregator irq_aggregator_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rdata   (reg_rdata),
    .irq_out     (irq_out),
    .en_q        (en_q),
    .mode_q      (mode_q),
    .hit         (hit),
    .clr_mask    (clr_mask),
    .sticky_q    (sticky_q),
    .status_view (status_view)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
    localparam int NCH  = 4;
    localparam int NS   = 20;
    localparam int RAND_CYCLES = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] src = '0;
    logic [15:0] fifo_flags;
    logic [3:0]  ser_irq;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    // R3: source bit ch*5+k maps onto the port bits
    always_comb begin
        for (int ch = 0; ch < NCH; ch++) begin
            for (int k = 0; k < 4; k++) fifo_flags[ch*4+k] = src[ch*5+k];
            ser_irq[ch] = src[ch*5+4];
        end
    end

    irq_aggregator u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_flags (fifo_flags),
        .ser_irq    (ser_irq),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_out    (irq_out)
    );

    // Reference model written from the requirements.
    logic [NS-1:0] m_s1, m_s2, m_prev, m_st, m_en, m_mode, m_sense;
    logic          m_irq;

    function automatic logic [NS-1:0] m_view();
        return (m_mode & (m_s2 ^ m_sense)) | (~m_mode & m_st);
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h60: return {12'h0, m_en};
            8'h64: return {12'h0, m_view()};
            8'h68: return {12'h0, m_mode};
            8'h6C: return {12'h0, m_sense};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_st <= '0;
            m_en <= '0; m_mode <= '0; m_sense <= '0; m_irq <= 1'b0;
        end else begin
            logic [NS-1:0] edge_hit, clr;
            edge_hit = ~m_mode & ((m_sense & m_prev & ~m_s2) | (~m_sense & m_s2 & ~m_prev));
            clr = (reg_wr && reg_addr == 8'h64) ? reg_wdata[NS-1:0] : '0;
            m_st   <= ~m_mode & ((m_st & ~clr) | edge_hit);
            m_irq  <= |(m_view() & m_en);
            if (reg_wr && reg_addr == 8'h60) m_en    <= reg_wdata[NS-1:0];
            if (reg_wr && reg_addr == 8'h68) m_mode  <= reg_wdata[NS-1:0];
            if (reg_wr && reg_addr == 8'h6C) m_sense <= reg_wdata[NS-1:0];
            m_s1 <= src; m_s2 <= m_s1; m_prev <= m_s2;
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            bad++;
            $display("FAIL %s: addr %h actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic irq_check(input logic exp, input string tag);
        checks++;
        if (irq_out !== exp) begin
            bad++;
            $display("FAIL %s: irq_out actual=%b expected=%b", tag, irq_out, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(3);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        rd_check(8'h60, 32'h0, "R1 enable");
        rd_check(8'h64, 32'h0, "R1 status");
        rd_check(8'h68, 32'h0, "R1 mode");
        rd_check(8'h6C, 32'h0, "R1 sense");
        irq_check(1'b0, "R1 irq");

        // R4/R12/R6: rising edge on ch0 tx-empty, source disabled
        src[0] = 1'b1;
        tick(2);
        rd_check(8'h64, 32'h0, "R12 not yet visible");
        tick();
        rd_check(8'h64, 32'h1, "R4 rising edge sets");
        irq_check(1'b0, "R6 disabled no irq");

        // R10: enabling raises output one clock later
        wr_reg(8'h60, 32'h1);
        irq_check(1'b0, "R10 registered delay");
        tick();
        irq_check(1'b1, "R10 enabled irq");

        // R11/R7: held until cleared
        tick(5);
        irq_check(1'b1, "R11 irq held");
        wr_reg(8'h64, 32'h0);
        rd_check(8'h64, 32'h1, "R7 zero write keeps");
        wr_reg(8'h64, 32'h1);
        rd_check(8'h64, 32'h0, "R7 one write clears");
        tick();
        irq_check(1'b0, "R11 irq falls after clear");

        // R3/R4: ch2 rx-full is bit 13; falling bit 0 sets nothing
        src[0] = 1'b0;
        src[13] = 1'b1;
        tick(3);
        rd_check(8'h64, 32'h2000, "R3 ch2 rx-full bit13");
        wr_reg(8'h64, 32'h2000);

        // R5: falling sense
        wr_reg(8'h6C, 32'h1);
        src[0] = 1'b1;
        tick(3);
        rd_check(8'h64, 32'h0, "R5 rising ignored");
        src[0] = 1'b0;
        tick(3);
        rd_check(8'h64, 32'h1, "R5 falling sets");
        wr_reg(8'h64, 32'h1);
        wr_reg(8'h6C, 32'h0);
        wr_reg(8'h60, 32'h0);

        // R9: level mode on ch3 serial request (bit 19)
        wr_reg(8'h68, 32'h80000);
        src[19] = 1'b1;
        tick(2);
        rd_check(8'h64, 32'h80000, "R9 level high disabled");
        wr_reg(8'h64, 32'h80000);
        rd_check(8'h64, 32'h80000, "R9 clear has no effect");
        wr_reg(8'h6C, 32'h80000);
        rd_check(8'h64, 32'h0, "R9 low sense inverts");
        src[19] = 1'b0;
        tick(2);
        rd_check(8'h64, 32'h80000, "R9 low level active");
        wr_reg(8'h60, 32'h80000);
        tick();
        irq_check(1'b1, "R10 level irq");
        src[19] = 1'b1;
        tick(2);
        rd_check(8'h64, 32'h0, "R9 level follows input");
        irq_check(1'b1, "R10 one cycle lag");
        tick();
        irq_check(1'b0, "R10 level irq falls");
        wr_reg(8'h60, 32'h0);
        wr_reg(8'h6C, 32'h0);
        src[19] = 1'b0;
        tick(3);
        wr_reg(8'h68, 32'h0);
        wr_reg(8'h64, 32'hFFFFFFFF);

        // R8: edge lands on the same edge as a clear write
        src[5] = 1'b1;
        tick(2);
        wr_reg(8'h64, 32'hFFFFFFFF);
        rd_check(8'h64, 32'h20, "R8 set wins over clear");
        wr_reg(8'h64, 32'h20);
        rd_check(8'h64, 32'h0, "R7 cleared after race");

        // R2: unmapped address and upper bits
        wr_reg(8'h70, 32'hFFFFFFFF);
        rd_check(8'h70, 32'h0, "R2 unmapped reads 0");
        rd_check(8'h60, 32'h0, "R2 unmapped write ignored");
        wr_reg(8'h60, 32'hFFFFFFFF);
        rd_check(8'h60, 32'h000FFFFF, "R2 upper bits zero");
        wr_reg(8'h60, 32'h0);

        // Random phase against the reference model (R4-R11)
        for (int c = 0; c < RAND_CYCLES; c++) begin
            logic [7:0] a;
            for (int b = 0; b < NS; b++)
                if ($urandom_range(15) == 0) src[b] = ~src[b];
            case ($urandom_range(4))
                0: a = 8'h60;
                1: a = 8'h64;
                2: a = 8'h68;
                3: a = 8'h6C;
                default: a = 8'h70;
            endcase
            reg_addr  = a;
            reg_wdata = $urandom();
            reg_wr    = ($urandom_range(7) == 0);
            #1;
            checks++;
            if (reg_rdata !== m_read(a)) begin
                bad++;
                $display("FAIL R2/R9 random read %h: actual=%h expected=%h", a, reg_rdata, m_read(a));
            end
            checks++;
            if (irq_out !== m_irq) begin
                bad++;
                $display("FAIL R10 random irq: actual=%b expected=%b", irq_out, m_irq);
            end
            tick();
        end
        reg_wr = 1'b0;

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule